// File: doc/BRIEF.md
# Parallel Camera Grayscale Line Capture

This block takes pixels from a parallel camera sensor that drives an 8-bit byte bus together with a pixel clock, a line sync and a frame sync. The camera signals are oversampled in the system clock domain. A two-flop synchroniser and edge detection bring them in, so the system clock must run at least four times faster than the pixel clock. Each pixel arrives as two bytes of RGB565. The block joins the two bytes and reduces the pixel to a gray level as soon as its second byte lands. It then writes the gray level into one half of a two-line ping-pong buffer.

Each finished line is read out of the buffer with a valid/ready handshake. The first pixel of every line carries a line-start marker. The first pixel of the first line after a frame sync also carries a frame-start marker. While one half of the buffer drains, the other half fills. A new line that finds both halves still occupied is discarded, and a sticky overrun flag is raised. The next frame sync clears that flag.

Top module: `cam_gray_capture`

## Requirements
- R1: Byte order and gray formula. The byte that arrives first is the high byte. R = high[7:3], G = {high[2:0], low[7:5]} and B = low[4:0]. The gray level is (R*154 + G*150 + B*58) >> 7, taken as an 8-bit integer.
- R2: A byte is taken only on a rising pixel-clock edge while the line sync is high. Bytes clocked while the line sync is low produce no output.
- R3: The pixels of a line leave in arrival order. out_sol is 1 on the first pixel of each line and 0 on every other pixel.
- R4: A rising frame-sync edge restarts the line count. out_sof is 1 only on the first pixel of the first line after that edge, and that pixel also has out_sol set.
- R5: There are two line stores. A line can be captured while the line before it is still being streamed out, and no data is lost while the consumer keeps up.
- R6: When a line-sync rising edge finds both stores occupied, that line is discarded whole and overrun becomes 1. overrun stays 1 until the next rising frame-sync edge. Lines captured after that edge are handled normally.
- R7: While out_valid is 1 and out_ready is 0, out_valid, out_data, out_sol and out_sof hold their values.
- R8: Pixels beyond LINE_PIX in one line are dropped, and only the first LINE_PIX are streamed. A line-sync pulse that carries no complete pixel produces no output.
- R9: After reset, out_valid and overrun are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cam_pclk | input | 1 | Camera pixel clock; bytes are sampled on its rising edge |
| cam_hsync | input | 1 | Line sync, high while the bytes of a line are on the bus |
| cam_vsync | input | 1 | Frame sync; its rising edge starts a frame |
| cam_data | input | 8 | Camera byte bus |
| out_data | output | 8 | Gray level of the output pixel |
| out_valid | output | 1 | Output pixel is valid |
| out_ready | input | 1 | Consumer accepts the pixel when high with out_valid |
| out_sol | output | 1 | First pixel of a line |
| out_sof | output | 1 | First pixel of the first line of a frame |
| overrun | output | 1 | Sticky flag: a line was dropped because both stores were full |

## Verification
Two events can land in the same clock. The reader can release a store on the very cycle the writer commits a finished line into the other store. A line-sync edge can also check for a free store while the reader is still holding the last pixel of the older line. Random gaps in out_ready, together with lines sent back to back, push the commit and the release close together. A stretch with out_ready held low fills both stores so that a third line hits the overrun path. A behavioural queue model in the bench judges every accepted pixel, including its markers, and checks on every clock that the output holds steady under backpressure.

// File: rtl/cam_gray_pkg.sv
package cam_gray_pkg;
  localparam int unsigned KR = 154;
  localparam int unsigned KG = 150;
  localparam int unsigned KB = 58;

  function automatic logic [7:0] rgb565_to_gray(input logic [7:0] hi, input logic [7:0] lo);
    logic [15:0] acc;
    acc = 16'(hi[7:3]) * 16'(KR)
        + 16'({hi[2:0], lo[7:5]}) * 16'(KG)
        + 16'(lo[4:0]) * 16'(KB);
    return acc[14:7];
  endfunction
endpackage

// File: rtl/cam_sync_edge.sv
module cam_sync_edge #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pclk_in,
  input  logic          hsync_in,
  input  logic          vsync_in,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] data_s,
  output logic          hsync_s,
  output logic          pclk_rise,
  output logic          hsync_rise,
  output logic          hsync_fall,
  output logic          vsync_rise
);
  localparam int SW = DW + 3;

  logic [SW-1:0] st1, st2;
  logic [2:0]    ctl_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      st1   <= '0;
      st2   <= '0;
      ctl_d <= '0;
    end else begin
      st1   <= {vsync_in, hsync_in, pclk_in, data_in};
      st2   <= st1;
      ctl_d <= st2[SW-1:DW];
    end
  end

  assign data_s     = st2[DW-1:0];
  assign hsync_s    = st2[DW+1];
  assign pclk_rise  = st2[DW]   & ~ctl_d[0];
  assign hsync_rise = st2[DW+1] & ~ctl_d[1];
  assign hsync_fall = ~st2[DW+1] & ctl_d[1];
  assign vsync_rise = st2[DW+2] & ~ctl_d[2];
endmodule

// File: rtl/cam_pixel_pack.sv
module cam_pixel_pack
  import cam_gray_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pclk_rise,
  input  logic       hsync_s,
  input  logic       hsync_rise,
  input  logic [7:0] data_s,
  output logic       pix_valid,
  output logic [7:0] pix_gray
);
  logic       second;
  logic [7:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      second    <= 1'b0;
      hi_q      <= '0;
      pix_valid <= 1'b0;
      pix_gray  <= '0;
    end else begin
      pix_valid <= 1'b0;
      if (hsync_rise) begin
        second <= 1'b0;
      end else if (pclk_rise && hsync_s) begin
        second <= ~second;
        if (!second) begin
          hi_q <= data_s;
        end else begin
          pix_valid <= 1'b1;
          pix_gray  <= rgb565_to_gray(hi_q, data_s);
        end
      end
    end
  end

  AST_PIX_FROM_EDGE: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> $past(pclk_rise && hsync_s)); // R2
endmodule

// File: rtl/cam_line_pingpong.sv
module cam_line_pingpong #(
  parameter int LINE_PIX = 128,
  parameter int CW       = $clog2(LINE_PIX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_bank,
  input  logic [CW-1:0] wr_idx,
  input  logic [7:0]    wr_data,
  input  logic          commit,
  input  logic [CW-1:0] commit_len,
  input  logic          commit_sof,
  output logic [1:0]    bank_full,
  output logic [7:0]    out_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_sol,
  output logic          out_sof
);
  localparam int DEPTH = 2 * LINE_PIX;
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]    mem [DEPTH];
  logic [7:0]    mem_q;
  logic [AW-1:0] waddr, raddr;
  logic [CW-1:0] len_q [2];
  logic [1:0]    sof_q;
  logic          rd_bank, rd_pend, issue, release_b, last;
  logic [CW-1:0] rd_idx;

  assign waddr = AW'(wr_idx) + (wr_bank ? AW'(LINE_PIX) : AW'(0));
  assign raddr = AW'(rd_idx) + (rd_bank ? AW'(LINE_PIX) : AW'(0));

  always_ff @(posedge clk) begin
    if (wr_en) mem[waddr] <= wr_data;
    mem_q <= mem[raddr];
  end

  assign issue     = bank_full[rd_bank] && !out_valid && !rd_pend;
  assign last      = (rd_idx == len_q[rd_bank] - CW'(1));
  assign release_b = rd_pend && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_full <= '0;
      sof_q     <= '0;
      len_q[0]  <= '0;
      len_q[1]  <= '0;
    end else begin
      if (commit) begin
        bank_full[wr_bank] <= 1'b1;
        len_q[wr_bank]     <= commit_len;
        sof_q[wr_bank]     <= commit_sof;
      end
      if (release_b) bank_full[rd_bank] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_bank   <= 1'b0;
      rd_idx    <= '0;
      rd_pend   <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sol   <= 1'b0;
      out_sof   <= 1'b0;
    end else begin
      rd_pend <= issue;
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (rd_pend) begin
        out_valid <= 1'b1;
        out_data  <= mem_q;
        out_sol   <= (rd_idx == '0);
        out_sof   <= (rd_idx == '0) && sof_q[rd_bank];
        if (last) begin
          rd_idx  <= '0;
          rd_bank <= ~rd_bank;
        end else begin
          rd_idx <= rd_idx + CW'(1);
        end
      end
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sol) && $stable(out_sof)); // R7
  AST_SOF_WITH_SOL: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_sof |-> out_sol); // R4
  AST_NO_WRITE_FULL: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !bank_full[wr_bank]); // R6
  AST_NO_COMMIT_FULL: assert property (@(posedge clk) disable iff (rst)
    commit |-> !bank_full[wr_bank] && commit_len != '0); // R5
endmodule

// File: rtl/cam_gray_capture.sv
module cam_gray_capture #(
  parameter int LINE_PIX    = 128,
  parameter int FRAME_LINES = 96
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cam_pclk,
  input  logic       cam_hsync,
  input  logic       cam_vsync,
  input  logic [7:0] cam_data,
  output logic [7:0] out_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic       out_sol,
  output logic       out_sof,
  output logic       overrun
);
  localparam int CW = $clog2(LINE_PIX + 1);
  localparam int LW = $clog2(FRAME_LINES + 1);

  logic [7:0]    data_s, pix_gray;
  logic          hsync_s, pclk_rise, hsync_rise, hsync_fall, vsync_rise, pix_valid;
  logic [1:0]    bank_full;
  logic          line_active, wr_bank, cur_sof, wr_en, commit;
  logic [CW-1:0] wr_cnt;
  logic [LW-1:0] line_cnt;

  cam_sync_edge #(.DW(8)) u_sync (
    .clk(clk), .rst(rst), .pclk_in(cam_pclk), .hsync_in(cam_hsync),
    .vsync_in(cam_vsync), .data_in(cam_data), .data_s(data_s), .hsync_s(hsync_s),
    .pclk_rise(pclk_rise), .hsync_rise(hsync_rise), .hsync_fall(hsync_fall),
    .vsync_rise(vsync_rise)
  );

  cam_pixel_pack u_pack (
    .clk(clk), .rst(rst), .pclk_rise(pclk_rise), .hsync_s(hsync_s),
    .hsync_rise(hsync_rise), .data_s(data_s), .pix_valid(pix_valid), .pix_gray(pix_gray)
  );

  assign wr_en  = pix_valid && line_active && (wr_cnt < CW'(LINE_PIX));
  assign commit = hsync_fall && line_active && (wr_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      line_active <= 1'b0;
      wr_bank     <= 1'b0;
      wr_cnt      <= '0;
      cur_sof     <= 1'b0;
      line_cnt    <= '0;
      overrun     <= 1'b0;
    end else begin
      if (wr_en) wr_cnt <= wr_cnt + CW'(1);
      if (vsync_rise) begin
        line_cnt <= '0;
        overrun  <= 1'b0;
      end
      if (hsync_rise) begin
        wr_cnt  <= '0;
        cur_sof <= vsync_rise || (line_cnt == '0);
        if (vsync_rise)                     line_cnt <= LW'(1);
        else if (line_cnt != LW'(FRAME_LINES)) line_cnt <= line_cnt + LW'(1);
        if (bank_full[wr_bank]) begin
          line_active <= 1'b0;
          overrun     <= 1'b1;
        end else begin
          line_active <= 1'b1;
        end
      end else if (hsync_fall) begin
        line_active <= 1'b0;
        if (commit) wr_bank <= ~wr_bank;
      end
    end
  end

  cam_line_pingpong #(.LINE_PIX(LINE_PIX), .CW(CW)) u_buf (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_cnt),
    .wr_data(pix_gray), .commit(commit), .commit_len(wr_cnt), .commit_sof(cur_sof),
    .bank_full(bank_full), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_sol(out_sol), .out_sof(out_sof)
  );

  AST_OVR_DROP: assert property (@(posedge clk) disable iff (rst)
    hsync_rise && bank_full[wr_bank] |=> overrun && !line_active); // R6
  AST_WCNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    wr_cnt <= CW'(LINE_PIX)); // R8
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    overrun && !vsync_rise |=> overrun); // R6
endmodule

// File: tb/cam_gray_capture_test.sv
module cam_gray_capture_test;
  localparam int CLK_NS = 10;
  localparam int LP     = 128;

  logic       clk = 1'b0, rst = 1'b1;
  logic       cam_pclk = 1'b0, cam_hsync = 1'b0, cam_vsync = 1'b0;
  logic [7:0] cam_data = '0;
  logic [7:0] out_data;
  logic       out_valid, out_ready = 1'b0, out_sol, out_sof, overrun;

  int total = 0, bad = 0, ready_mode = 1, lidx = 0, cycles = 0;
  logic [7:0] exp_d[$];
  bit         exp_sol[$], exp_sof[$];
  logic       prev_stall = 1'b0;
  logic [7:0] prev_d;
  logic       prev_sol, prev_sof;

  always #(CLK_NS/2) clk = ~clk;

  cam_gray_capture uut (
    .clk(clk), .rst(rst), .cam_pclk(cam_pclk), .cam_hsync(cam_hsync),
    .cam_vsync(cam_vsync), .cam_data(cam_data), .out_data(out_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_sol(out_sol),
    .out_sof(out_sof), .overrun(overrun)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  function automatic int gray_ref(input logic [15:0] w);
    int r, g, b;
    r = int'(w[15:11]); g = int'(w[10:5]); b = int'(w[4:0]);
    return (r*2*77 + g*150 + b*2*29) / 128;
  endfunction

  function automatic logic [15:0] pix_word(input int ln, input int i);
    case (i)
      0: return 16'hF800;
      1: return 16'h07E0;
      2: return 16'h001F;
      3: return 16'hFFFF;
      4: return 16'h0000;
      default: return 16'((ln*97 + i*131) * 53 ^ (i*7));
    endcase
  endfunction

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); cam_data = b; cam_pclk = 1'b0;
    repeat (4) @(negedge clk);
    cam_pclk = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic frame_sync();
    @(negedge clk); cam_vsync = 1'b1;
    repeat (6) @(negedge clk); cam_vsync = 1'b0;
    repeat (6) @(negedge clk);
    lidx = 0;
  endtask

  task automatic send_line(input int npix, input int ln, input bit dropped);
    bit sof;
    sof = (lidx == 0);
    lidx++;
    @(negedge clk); cam_pclk = 1'b0; cam_hsync = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < npix; i++) begin
      logic [15:0] w;
      w = pix_word(ln, i);
      send_byte(w[15:8]);
      send_byte(w[7:0]);
      if (!dropped && i < LP) begin
        exp_d.push_back(8'(gray_ref(w)));
        exp_sol.push_back(i == 0);
        exp_sof.push_back(sof && i == 0);
      end
    end
    @(negedge clk); cam_pclk = 1'b0;
    repeat (4) @(negedge clk); cam_hsync = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic wait_drain();
    while (exp_d.size() != 0) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  // ready driver, changes just after posedge
  initial begin
    forever begin
      @(posedge clk); #1;
      case (ready_mode)
        0: out_ready = 1'b0;
        1: out_ready = 1'b1;
        default: out_ready = ($urandom % 3) != 0;
      endcase
    end
  end

  // per-clock comparison against the queue model
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall)
        chk(out_valid && out_data == prev_d && out_sol == prev_sol && out_sof == prev_sof,
            "R7 hold under backpressure", int'(out_data), int'(prev_d));
      if (out_valid && out_ready) begin
        if (exp_d.size() == 0) begin
          chk(1'b0, "R3/R2 unexpected pixel", int'(out_data), -1);
        end else begin
          logic [7:0] ed; bit es, ef;
          ed = exp_d.pop_front(); es = exp_sol.pop_front(); ef = exp_sof.pop_front();
          chk(out_data == ed, "R1 gray value", int'(out_data), int'(ed));
          chk(out_sol == es, "R3 line start marker", int'(out_sol), int'(es));
          chk(out_sof == ef, "R4 frame start marker", int'(out_sof), int'(ef));
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_d = out_data; prev_sol = out_sol; prev_sof = out_sof;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        chk(1'b0, "watchdog", cycles, 150000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R9 reset out_valid", int'(out_valid), 0);
    chk(overrun == 1'b0, "R9 reset overrun", int'(overrun), 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0 && overrun == 1'b0, "R9 idle after reset", int'(out_valid), 0);

    // R1 R3 R4: plain lines, consumer always ready
    ready_mode = 1;
    frame_sync();
    send_line(8, 1, 0);
    send_line(8, 2, 0);
    wait_drain();

    // R5 R7: back-to-back lines with random backpressure
    ready_mode = 2;
    send_line(20, 3, 0);
    send_line(20, 4, 0);
    send_line(20, 5, 0);
    wait_drain();

    // R2: bytes outside line sync; R8: empty line pulse
    for (int k = 0; k < 4; k++) send_byte(8'hA5);
    send_line(0, 6, 0);
    repeat (60) @(negedge clk);
    chk(exp_d.size() == 0 && !out_valid, "R2/R8 no output from stray bytes", int'(out_valid), 0);
    send_line(5, 7, 0);

    // R8: overlong line truncated to LINE_PIX
    send_line(LP + 2, 8, 0);
    wait_drain();
    chk(!out_valid, "R8 truncated line fully drained", int'(out_valid), 0);

    // R6: fill both stores, third line dropped
    ready_mode = 0;
    frame_sync();
    send_line(4, 9, 0);
    send_line(4, 10, 0);
    chk(overrun == 1'b0, "R6 no overrun with one free store", int'(overrun), 0);
    send_line(4, 11, 1);
    chk(overrun == 1'b1, "R6 overrun set on drop", int'(overrun), 1);
    ready_mode = 1;
    wait_drain();
    chk(overrun == 1'b1, "R6 overrun sticky", int'(overrun), 1);
    frame_sync();
    chk(overrun == 1'b0, "R6 overrun cleared by frame sync", int'(overrun), 0);
    send_line(6, 12, 0);
    wait_drain();
    chk(exp_d.size() == 0 && !out_valid, "R5 all expected pixels delivered", exp_d.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule